// File: doc/BRIEF.md
# Converter Serial Frame Port

This block is the device side of the serial port on a four-channel, 12-bit sampling converter. A host drives a chip select (`cs_n`), a serial clock (`sclk`) and a serial data line (`din`). All three are sampled on the system clock `clk`. Every frame begins when `cs_n` falls. At that point the block opens its data output and loads a 16-bit readout word. The word holds two zero bits, the tag of the channel the sample belongs to, and the 12-bit result taken from `conv_data`.

The readout word leaves MSB first, one bit for each `sclk` falling edge. At the same time the block shifts in a control word from `din`. A frame is complete after 16 falling edges, and only then may the captured control word change the block's channel state. A frame that `cs_n` cuts short leaves that state untouched.

The channel is chosen in one of two ways. In manual mode the programmed channel is held. In sequence mode every `cs_n` falling edge steps the channel multiplexer onward, and frames that only write still cause a step. The converter stand-in reads `mux_ch` and returns the matching result on `conv_data`.

Top module: `adc_frame_port`

## Requirements
- R1: After reset `dout_oe` is 0, `mux_ch` is 0 and sequence mode is off.
- R2: In the first clock cycle after a `cs_n` falling edge has been sampled, `dout_oe` is 1 and `dout` shows the first bit of the word, which is 0.
- R3: The readout word, from first bit to last, is 0, 0, channel tag bit 1, channel tag bit 0, then result bits 11 down to 0. Bit k (k = 1..15) appears on `dout` after the k-th `sclk` falling edge of the frame.
- R4: `dout_oe` stays 1 up to and including the 15th falling edge and drops on the 16th. Any further `sclk` edges while `cs_n` stays low have no effect.
- R5: `din` is captured MSB first on the first 12 falling edges, forming control bits 11..0. Bit 11 is the write bit. Bit 10 enables sequence mode, bits 9:8 give the channel and bits 7:6 give the last channel of the sequence. Bits 5:0 and the `din` values on edges 13 to 16 are ignored.
- R6: If `cs_n` rises before the 16th falling edge, `dout_oe` drops in the next cycle and the captured word is discarded.
- R7: With the write bit set, the fields take effect only on the 16th falling edge, and `mux_ch` becomes the programmed channel. A complete frame whose write bit is 0 changes nothing.
- R8: In manual mode `mux_ch` does not change on a `cs_n` falling edge.
- R9: In sequence mode each `cs_n` falling edge moves `mux_ch` to the next channel. After the last channel it wraps to 0, and the same happens when the current channel is above the last one. Aborted frames and write-only frames also cause a step.
- R10: The tag in a frame is the `mux_ch` value in force when `cs_n` fell, and the result bits are the `conv_data` value present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock; falling edges advance the frame |
| din | input | 1 | Host serial data toward the control word |
| dout | output | 1 | Serial readout bit |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |
| mux_ch | output | 2 | Channel currently selected for conversion |
| conv_data | input | 12 | Conversion result for `mux_ch` |

## Verification
The bench instantiates the block with its default values: a 12-bit result, a 2-bit channel tag and a 12-bit control word. With these values the frame is 16 edges long and there are four channels. This keeps both wrap points of the sequence reachable within a few frames: a last channel of 2 and a last channel of 3. It also puts the write-bit edge, the final capture edge and the completion edge at positions that are easy to tell apart. Aborts after 3 edges and after 15 edges check that early termination discards the control word whether or not all of its bits have been shifted in.

// File: rtl/adc_frame_port.sv
module adc_frame_port #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 2,
  parameter int CTRL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic [CH_W-1:0]   mux_ch,
  input  logic [DATA_W-1:0] conv_data
);
  localparam int FRAME_LEN = DATA_W + CH_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int WR_BIT    = CTRL_W - 1;
  localparam int SEQ_BIT   = CTRL_W - 2;
  localparam int ADDR_HI   = CTRL_W - 3;
  localparam int LAST_HI   = ADDR_HI - CH_W;

  logic                 cs_q, sclk_q, active, seq_en;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] shreg;
  logic [CTRL_W-1:0]    ctrl_sh;
  logic [CH_W-1:0]      cur_ch, last_ch, nxt_ch;

  wire cs_fall   = cs_q & ~cs_n;
  wire sclk_fall = sclk_q & ~sclk;

  assign nxt_ch  = (cur_ch >= last_ch) ? '0 : cur_ch + CH_W'(1);
  assign dout    = shreg[FRAME_LEN-1];
  assign dout_oe = active;
  assign mux_ch  = cur_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      active  <= 1'b0;
      seq_en  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      ctrl_sh <= '0;
      cur_ch  <= '0;
      last_ch <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n) begin
        active <= 1'b0;
      end else if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= {2'b00, cur_ch, conv_data};
        if (seq_en) cur_ch <= nxt_ch;
      end else if (active && sclk_fall) begin
        cnt   <= cnt + CNT_W'(1);
        shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
        if (cnt < CNT_W'(CTRL_W)) ctrl_sh <= {ctrl_sh[CTRL_W-2:0], din};
        if (cnt == CNT_W'(FRAME_LEN - 1)) begin
          active <= 1'b0;
          if (ctrl_sh[WR_BIT]) begin
            seq_en  <= ctrl_sh[SEQ_BIT];
            cur_ch  <= ctrl_sh[ADDR_HI -: CH_W];
            last_ch <= ctrl_sh[LAST_HI -: CH_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_port_chk.sv
module adc_frame_port_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            dout,
  input logic            dout_oe,
  input logic [CH_W-1:0] mux_ch,
  input logic            seq_en
);
  AST_OPEN_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |=> dout_oe && !dout); // R2
  AST_CLOSED_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !dout_oe); // R6
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) && !seq_en |=> $stable(mux_ch)); // R8
  AST_MUX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mux_ch) |-> $fell(dout_oe) || $past($fell(cs_n))); // R9
endmodule

bind adc_frame_port adc_frame_port_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout),
  .dout_oe(dout_oe), .mux_ch(mux_ch), .seq_en(seq_en)
);

// File: tb/adc_frame_port_tb.sv
`timescale 1ns/1ps
module adc_frame_port_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  logic [1:0] mux_ch;
  logic [11:0] conv_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [11:0] sample_of(input logic [1:0] ch);
    return 12'h9C3 ^ (12'(ch) * 12'h155);
  endfunction

  assign conv_data = sample_of(mux_ch);

  adc_frame_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .mux_ch(mux_ch), .conv_data(conv_data)
  );

  // {din word, sclk falls, expected tag, expected mux_ch afterwards}
  localparam logic [24:0] VEC [0:18] = '{
    {16'h0003, 5'd16, 2'd0, 2'd0},
    {16'hA00F, 5'd16, 2'd0, 2'd2},
    {16'h0000, 5'd16, 2'd2, 2'd2},
    {16'h900F, 5'd15, 2'd2, 2'd2},
    {16'h0003, 5'd16, 2'd2, 2'd2},
    {16'h7C0F, 5'd16, 2'd2, 2'd2},
    {16'h0000, 5'd16, 2'd2, 2'd2},
    {16'hD80F, 5'd16, 2'd2, 2'd1},
    {16'h0000, 5'd16, 2'd1, 2'd2},
    {16'h0003, 5'd16, 2'd2, 2'd0},
    {16'h0000, 5'd16, 2'd0, 2'd1},
    {16'h0000, 5'd3,  2'd1, 2'd2},
    {16'h0000, 5'd16, 2'd2, 2'd0},
    {16'hFC0F, 5'd16, 2'd0, 2'd3},
    {16'h0000, 5'd16, 2'd3, 2'd0},
    {16'h0000, 5'd16, 2'd0, 2'd1},
    {16'h900F, 5'd16, 2'd1, 2'd1},
    {16'h0000, 5'd18, 2'd1, 2'd1},
    {16'h0003, 5'd16, 2'd1, 2'd1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nfall, input logic [1:0] tag, input logic [1:0] exp_mux);
    logic [15:0] got, expw, mask;
    int kept;
    got = '0;
    cs_n = 1'b0;
    tick(2);
    check(dout_oe == 1'b1, "R2 oe after select", 32'(dout_oe), 1);
    check(dout == 1'b0, "R2 first bit", 32'(dout), 0);
    got[15] = dout;
    for (int i = 1; i <= nfall; i++) begin
      din = (i <= 16) ? w[16-i] : 1'b1;
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(2);
      if (i <= 15) got[15-i] = dout;
      if (i == 15) check(dout_oe == 1'b1, "R4 oe held to 15th", 32'(dout_oe), 1);
      if (i >= 16) check(dout_oe == 1'b0, "R4 oe off from 16th", 32'(dout_oe), 0);
    end
    cs_n = 1'b1;
    tick(1);
    check(dout_oe == 1'b0, "R6 oe off on deselect", 32'(dout_oe), 0);
    tick(2);
    kept = (nfall > 15 ? 15 : nfall) + 1;
    mask = 16'hFFFF << (16 - kept);
    expw = {2'b00, tag, sample_of(tag)};
    check((got & mask) == (expw & mask), "R3 R10 readout word", 32'(got & mask), 32'(expw & mask));
    check(mux_ch == exp_mux, "R5 R7 R8 R9 channel state", 32'(mux_ch), 32'(exp_mux));
  endtask

  initial begin
    tick(3);
    check(dout_oe == 1'b0, "R1 oe in reset", 32'(dout_oe), 0);
    check(mux_ch == 2'd0, "R1 mux in reset", 32'(mux_ch), 0);
    rst_n = 1'b1;
    tick(2);
    check(dout_oe == 1'b0 && mux_ch == 2'd0, "R1 after reset", {dout_oe, mux_ch}, 0);
    foreach (VEC[k]) frame(VEC[k][24:9], int'(VEC[k][8:4]), VEC[k][3:2], VEC[k][1:0]);
    // enter sequence mode, then reset mid-run: state must return to channel 0, manual
    frame(16'hFC0F, 16, 2'd1, 2'd3);
    rst_n = 1'b0;
    tick(2);
    check(mux_ch == 2'd0 && dout_oe == 1'b0, "R1 mid-run reset", {dout_oe, mux_ch}, 0);
    rst_n = 1'b1;
    tick(2);
    frame(16'h0000, 16, 2'd0, 2'd0);
    frame(16'h0000, 16, 2'd0, 2'd0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule